// File: doc/BRIEF.md
# Chip Sleep Handshake Controller

This block coordinates whole-chip sleep between two cooperating sides. A clock-management side turns a software-armed idle request into a request to the PLLs. Once the PLLs confirm they are idle, it raises a chip-idle indication. A sleep sequencer on the always-on clock answers chip-idle by gating the 12 MHz reference clock. At the same time it drops the SDRAM clock enable, asserts the flash power-down output and pulls an active-low acknowledge low to report that the clock is off.

Any wake source sets a combinational wake request: a processor interrupt, a second-processor interrupt, a DMA request or local bus activity. The wake request pulls chip-idle down and starts a programmable settle count. When the count runs out, the sequencer restores the reference clock enable, the SDRAM enable and flash power. It releases the acknowledge one cycle later. If a wake arrives before the clock has been gated, entry is abandoned and the clock keeps running. A status word holds the last cycle's chip-idle, wake-request and acknowledge levels so that software can read them.

Top module: `chip_sleep_ctrl`

## Requirements
- R1: During and after reset the outputs are: chip_idle 0, pll_idle_req 0, wake_ack_n 1, ref_clk_en 1, sdram_clk_en 1, flash_pd 0 and status 3'b100.
- R2: pll_idle_req goes high one cycle after a clock edge that sees idle_arm=1, wake_req=0 and wake_ack_n=1. While chip_idle is still low, it drops one cycle after an edge that sees idle_arm=0 or wake_req=1.
- R3: chip_idle rises one cycle after an edge at which pll_idle_req is high, pll_idle_ack=1, idle_arm=1 and wake_req=0. It never rises without that acknowledge.
- R4: wake_req is the OR of wake_src in the same cycle, with no register. The bits are 0 for a processor interrupt, 1 for a second-processor interrupt, 2 for a DMA request and 3 for local bus activity.
- R5: When an edge sees chip_idle=1, wake_req=0 and wake_ack_n=1, the block enters its sleep state on the next cycle. In that state ref_clk_en=0, sdram_clk_en=0, flash_pd=1 and wake_ack_n=0.
- R6: A wake seen while asleep clears chip_idle on the next cycle. ref_clk_en, sdram_clk_en and flash_pd then keep their sleep values for settle_len+1 further cycles. They are restored together, and wake_ack_n goes high exactly one cycle after that. The value settle_len=16 is the intended default.
- R7: A wake seen while chip_idle is low, or in the first cycle that chip_idle is high, returns the request side to idle-free operation. In that case ref_clk_en never drops.
- R8: status holds the previous cycle's values: bit 0 is chip_idle, bit 1 is wake_req and bit 2 is wake_ack_n.
- R9: ref_clk_out equals ref_clk while the latched enable is 1 and is held low while it is 0. The enable latch takes ref_clk_en only while ref_clk is low.
- R10: Once chip_idle is high, only a wake clears it. Dropping idle_arm has no effect, and wake sources or idle_arm seen during the settle count do not change its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Ungated reference clock |
| idle_arm | input | 1 | Software idle-entry arm bit |
| pll_idle_ack | input | 1 | PLLs report idle |
| wake_src | input | NUM_WAKE (4) | Wake conditions, bit meanings in R4 |
| settle_len | input | CNT_W (5) | Settle count after wake |
| wake_req | output | 1 | Combined wake request |
| pll_idle_req | output | 1 | Idle request to the PLLs |
| chip_idle | output | 1 | Chip may stop its reference clock |
| wake_ack_n | output | 1 | Low while the reference clock is off or settling |
| ref_clk_en | output | 1 | Reference clock enable before the latch |
| ref_clk_out | output | 1 | Glitch-free gated reference clock |
| sdram_clk_en | output | 1 | SDRAM clock enable |
| flash_pd | output | 1 | Flash power-down |
| status | output | 3 | Status word, bits in R8 |

## Verification
Idle entry and wake can meet in the same cycle. The bench raises a wake source in the very cycle chip-idle first shows high, and again in the cycle the PLL acknowledge arrives. It judges each case by the clock enable never dropping and the acknowledge staying high. A second collision is a wake source raised during the settle count, which must not stretch or cut the count. A behavioural reference model is compared with every output on every cycle, so the timing of each of these collisions is checked exactly.

// File: rtl/chip_sleep_pkg.sv
package chip_sleep_pkg;
   typedef enum logic [1:0] {
      REQ_RUN  = 2'd0,
      REQ_WAIT = 2'd1,
      REQ_IDLE = 2'd2
   } req_state_e;

   typedef enum logic [1:0] {
      SEQ_AWAKE   = 2'd0,
      SEQ_GATED   = 2'd1,
      SEQ_SETTLE  = 2'd2,
      SEQ_RESTORE = 2'd3
   } seq_state_e;

   localparam int STAT_W       = 3;
   localparam int STAT_IDLE_B  = 0;
   localparam int STAT_WAKE_B  = 1;
   localparam int STAT_ACK_B   = 2;
endpackage

// File: rtl/wake_merge.sv
module wake_merge #(
   parameter int NUM_WAKE = 4
) (
   input  logic [NUM_WAKE-1:0] src,
   output logic                wake
);
   assign wake = |src;
endmodule

// File: rtl/idle_request_fsm.sv
module idle_request_fsm
   import chip_sleep_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic idle_arm,
   input  logic pll_idle_ack,
   input  logic wake,
   input  logic seq_awake,
   output logic chip_idle,
   output logic pll_idle_req
);
   req_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         REQ_RUN:  if (idle_arm && !wake && seq_awake) st_d = REQ_WAIT;
         REQ_WAIT: begin
            if (wake || !idle_arm) st_d = REQ_RUN;
            else if (pll_idle_ack) st_d = REQ_IDLE;
         end
         REQ_IDLE: if (wake) st_d = REQ_RUN;
         default:  st_d = REQ_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= REQ_RUN;
      else        st_q <= st_d;
   end

   assign chip_idle    = (st_q == REQ_IDLE);
   assign pll_idle_req = (st_q != REQ_RUN);
endmodule

// File: rtl/sleep_seq_fsm.sv
module sleep_seq_fsm
   import chip_sleep_pkg::*;
#(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chip_idle,
   input  logic             wake,
   input  logic [CNT_W-1:0] settle_len,
   output logic             ref_clk_en,
   output logic             wake_ack_n,
   output logic             sdram_clk_en,
   output logic             flash_pd
);
   seq_state_e       st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      unique case (st_q)
         SEQ_AWAKE: if (chip_idle && !wake) st_d = SEQ_GATED;
         SEQ_GATED: if (wake) begin
            st_d  = SEQ_SETTLE;
            cnt_d = settle_len;
         end
         SEQ_SETTLE: begin
            if (cnt_q == '0) st_d = SEQ_RESTORE;
            else             cnt_d = cnt_q - 1'b1;
         end
         SEQ_RESTORE: if (!chip_idle) st_d = SEQ_AWAKE;
         default: st_d = SEQ_AWAKE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= SEQ_AWAKE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   logic clk_off;
   assign clk_off      = (st_q == SEQ_GATED) || (st_q == SEQ_SETTLE);
   assign ref_clk_en   = !clk_off;
   assign sdram_clk_en = !clk_off;
   assign flash_pd     = clk_off;
   assign wake_ack_n   = (st_q == SEQ_AWAKE);
endmodule

// File: rtl/ref_clk_gate.sv
module ref_clk_gate (
   input  logic rst_n,
   input  logic ref_clk,
   input  logic en,
   output logic gclk
);
   logic en_l;

   always_latch begin
      if (!rst_n)        en_l = 1'b1;
      else if (!ref_clk) en_l = en;
   end

   assign gclk = ref_clk & en_l;
endmodule

// File: rtl/chip_sleep_ctrl.sv
module chip_sleep_ctrl
   import chip_sleep_pkg::*;
#(
   parameter int NUM_WAKE   = 4,
   parameter int CNT_W      = 5,
   parameter bit STATUS_REG = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ref_clk,
   input  logic                idle_arm,
   input  logic                pll_idle_ack,
   input  logic [NUM_WAKE-1:0] wake_src,
   input  logic [CNT_W-1:0]    settle_len,
   output logic                wake_req,
   output logic                pll_idle_req,
   output logic                chip_idle,
   output logic                wake_ack_n,
   output logic                ref_clk_en,
   output logic                ref_clk_out,
   output logic                sdram_clk_en,
   output logic                flash_pd,
   output logic [STAT_W-1:0]   status
);
   initial begin
      assert (NUM_WAKE >= 1) else $error("NUM_WAKE must be at least 1");
      assert (CNT_W >= 1 && CNT_W <= 16) else $error("CNT_W out of range");
   end

   wake_merge #(.NUM_WAKE(NUM_WAKE)) u_wake (
      .src  (wake_src),
      .wake (wake_req)
   );

   idle_request_fsm u_req (
      .clk          (clk),
      .rst_n        (rst_n),
      .idle_arm     (idle_arm),
      .pll_idle_ack (pll_idle_ack),
      .wake         (wake_req),
      .seq_awake    (wake_ack_n),
      .chip_idle    (chip_idle),
      .pll_idle_req (pll_idle_req)
   );

   sleep_seq_fsm #(.CNT_W(CNT_W)) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .chip_idle    (chip_idle),
      .wake         (wake_req),
      .settle_len   (settle_len),
      .ref_clk_en   (ref_clk_en),
      .wake_ack_n   (wake_ack_n),
      .sdram_clk_en (sdram_clk_en),
      .flash_pd     (flash_pd)
   );

   ref_clk_gate u_gate (
      .rst_n   (rst_n),
      .ref_clk (ref_clk),
      .en      (ref_clk_en),
      .gclk    (ref_clk_out)
   );

   logic [STAT_W-1:0] stat_now;
   always_comb begin
      stat_now              = '0;
      stat_now[STAT_IDLE_B] = chip_idle;
      stat_now[STAT_WAKE_B] = wake_req;
      stat_now[STAT_ACK_B]  = wake_ack_n;
   end

   generate
      if (STATUS_REG) begin : g_stat_reg
         logic [STAT_W-1:0] stat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stat_q <= STAT_W'(1) << STAT_ACK_B;
            else        stat_q <= stat_now;
         end
         assign status = stat_q;
      end else begin : g_stat_flow
         assign status = stat_now;
      end
   endgenerate
endmodule

// File: rtl/chip_sleep_ctrl_chk.sv
module chip_sleep_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       idle_arm,
   input logic       pll_idle_ack,
   input logic       wake_req,
   input logic       pll_idle_req,
   input logic       chip_idle,
   input logic       wake_ack_n,
   input logic       ref_clk_en,
   input logic       sdram_clk_en,
   input logic       flash_pd,
   input logic [2:0] status
);
   logic run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= 1'b0;
      else        run_q <= 1'b1;
   end

   a_r2_req_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_idle_req) |-> $past(idle_arm) && $past(wake_ack_n) && !$past(wake_req));

   a_r3_idle_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chip_idle) |-> $past(pll_idle_ack) && $past(idle_arm));

   a_r5_clock_off_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_clk_en |-> !wake_ack_n && !sdram_clk_en && flash_pd);

   a_r6_restore_before_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wake_ack_n) |-> $past(ref_clk_en) && $past(sdram_clk_en) && !$past(flash_pd) && !chip_idle);

   a_r7_awake_wake_keeps_clock: assert property (@(posedge clk) disable iff (!rst_n)
      wake_req && wake_ack_n |=> ref_clk_en);

   a_r8_status_history: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> status == {$past(wake_ack_n), $past(wake_req), $past(chip_idle)});

   a_r10_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      chip_idle && !wake_req |=> chip_idle);
endmodule

bind chip_sleep_ctrl chip_sleep_ctrl_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .idle_arm     (idle_arm),
   .pll_idle_ack (pll_idle_ack),
   .wake_req     (wake_req),
   .pll_idle_req (pll_idle_req),
   .chip_idle    (chip_idle),
   .wake_ack_n   (wake_ack_n),
   .ref_clk_en   (ref_clk_en),
   .sdram_clk_en (sdram_clk_en),
   .flash_pd     (flash_pd),
   .status       (status)
);

// File: tb/chip_sleep_ctrl_test.sv
module chip_sleep_ctrl_test;
   logic       clk = 1'b0;
   logic       ref_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       idle_arm = 1'b0;
   logic       pll_idle_ack = 1'b0;
   logic [3:0] wake_src = 4'h0;
   logic [4:0] settle_len = 5'd16;
   logic       wake_req, pll_idle_req, chip_idle, wake_ack_n;
   logic       ref_clk_en, ref_clk_out, sdram_clk_en, flash_pd;
   logic [2:0] status;

   always #10 clk = ~clk;
   always #8  ref_clk = ~ref_clk;

   chip_sleep_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .idle_arm(idle_arm),
      .pll_idle_ack(pll_idle_ack), .wake_src(wake_src), .settle_len(settle_len),
      .wake_req(wake_req), .pll_idle_req(pll_idle_req), .chip_idle(chip_idle),
      .wake_ack_n(wake_ack_n), .ref_clk_en(ref_clk_en), .ref_clk_out(ref_clk_out),
      .sdram_clk_en(sdram_clk_en), .flash_pd(flash_pd), .status(status)
   );

   // behavioural reference: request side 0 run,1 waiting,2 idle;
   // sleep side 0 awake,1 asleep,2 settling,3 restored
   int       m_req, m_seq, m_cnt, m_age;
   bit [2:0] m_stat;
   int       vectors = 0;
   int       errors  = 0;
   int       cycles  = 0;
   bit       done    = 1'b0;

   function automatic bit m_idle();  return m_req == 2; endfunction
   function automatic bit m_ackn();  return m_seq == 0; endfunction
   function automatic bit m_en();    return !(m_seq == 1 || m_seq == 2); endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_req = 0; m_seq = 0; m_cnt = 0; m_age = 0; m_stat = 3'b100;
      end else begin
         bit w, ci, an, en_old;
         w = (wake_src != 0);
         ci = m_idle(); an = m_ackn(); en_old = m_en();
         m_stat = {an, w, ci};
         case (m_req)
            0: if (idle_arm && !w && an) m_req = 1;
            1: if (w || !idle_arm) m_req = 0; else if (pll_idle_ack) m_req = 2;
            default: if (w) m_req = 0;
         endcase
         case (m_seq)
            0: if (ci && !w) m_seq = 1;
            1: if (w) begin m_seq = 2; m_cnt = settle_len; end
            2: if (m_cnt == 0) m_seq = 3; else m_cnt--;
            default: if (!ci) m_seq = 0;
         endcase
         if (m_en() != en_old) m_age = 0; else m_age++;
      end
   end

   task automatic chk(input string req, input string nm, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, nm, act, exp, $time);
      end
   endtask

   task automatic compare();
      bit w;
      w = (wake_src != 0);
      chk("R4", "wake_req", wake_req, w);
      chk("R2", "pll_idle_req", pll_idle_req, m_req != 0);
      chk("R3", "chip_idle", chip_idle, m_idle());
      chk("R5", "wake_ack_n", wake_ack_n, m_ackn());
      chk("R6", "ref_clk_en", ref_clk_en, m_en());
      chk("R6", "sdram_clk_en", sdram_clk_en, m_en());
      chk("R6", "flash_pd", flash_pd, !m_en());
      chk("R8", "status", status, m_stat);
      if (m_age >= 1) chk("R9", "ref_clk_out", ref_clk_out, ref_clk & m_en());
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         compare();
      end
   endtask

   int gated_seen;
   always @(negedge clk) if (rst_n && !ref_clk_en) gated_seen++;

   task automatic sleep_wake(input int src_bit, input int settle);
      settle_len = 5'(settle);
      idle_arm = 1'b1; pll_idle_ack = 1'b1;
      tick(4);
      chk("R5", "asleep ack_n", wake_ack_n, 0);
      idle_arm = 1'b0; pll_idle_ack = 1'b0;
      tick(2);
      chk("R10", "idle kept after arm drop", chip_idle, 1);
      wake_src = 4'(1 << src_bit);
      tick(1);
      wake_src = 4'h0;
      tick(settle + 4);
      chk("R6", "awake after settle", wake_ack_n, 1);
   endtask

   initial begin
      tick(3);
      chk("R1", "reset ack_n", wake_ack_n, 1);
      chk("R1", "reset ref_clk_en", ref_clk_en, 1);
      chk("R1", "reset status", status, 3'b100);
      rst_n = 1'b1;
      tick(2);

      // R4 / R6: full cycles, each wake source, several settle lengths
      sleep_wake(0, 0);
      sleep_wake(1, 3);
      sleep_wake(2, 16);
      sleep_wake(3, 31);

      // R7: abort while waiting for the PLL acknowledge
      gated_seen = 0;
      idle_arm = 1'b1;
      tick(3);
      chk("R2", "waiting request", pll_idle_req, 1);
      wake_src = 4'b0100;
      tick(1);
      wake_src = 4'h0; idle_arm = 1'b0;
      tick(3);
      chk("R7", "no gating on abort in wait", gated_seen, 0);

      // R7: wake coincides with the PLL acknowledge
      idle_arm = 1'b1;
      tick(2);
      pll_idle_ack = 1'b1; wake_src = 4'b0001;
      tick(1);
      wake_src = 4'h0; idle_arm = 1'b0; pll_idle_ack = 1'b0;
      tick(3);
      chk("R7", "no gating on ack collision", gated_seen, 0);

      // R7: wake in the first cycle chip_idle is high
      idle_arm = 1'b1; pll_idle_ack = 1'b1;
      tick(2);
      chk("R3", "idle just risen", chip_idle, 1);
      wake_src = 4'b1000;
      tick(1);
      wake_src = 4'h0; idle_arm = 1'b0; pll_idle_ack = 1'b0;
      tick(4);
      chk("R7", "no gating on first-cycle wake", gated_seen, 0);

      // R2: arm dropped during wait
      idle_arm = 1'b1;
      tick(2);
      idle_arm = 1'b0;
      tick(2);
      chk("R2", "request withdrawn", pll_idle_req, 0);

      // R3: acknowledge without arm ignored
      pll_idle_ack = 1'b1;
      tick(4);
      chk("R3", "no idle without arm", chip_idle, 0);
      pll_idle_ack = 1'b0;

      // R10: wake sources during settle do not change its length
      settle_len = 5'd8;
      idle_arm = 1'b1; pll_idle_ack = 1'b1;
      tick(4);
      idle_arm = 1'b0; pll_idle_ack = 1'b0;
      wake_src = 4'b0010;
      tick(1);
      wake_src = 4'b0000; tick(2);
      wake_src = 4'b1111; idle_arm = 1'b1; tick(3);
      wake_src = 4'b0000; tick(6);
      idle_arm = 1'b0;
      tick(3);

      // R1: reset in the middle of sleep
      idle_arm = 1'b1; pll_idle_ack = 1'b1;
      tick(4);
      @(negedge clk);
      rst_n = 1'b0; idle_arm = 1'b0; pll_idle_ack = 1'b0;
      tick(1);
      chk("R1", "reset mid-sleep en", ref_clk_en, 1);
      rst_n = 1'b1;
      tick(3);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule